// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block decides what the program counter and the privilege level become at the end of each retiring instruction. An execution unit may report a synchronous fault as a 4-bit cause code. An interrupt source may present its own 4-bit vector code. When either is present, the sequencer does not let the instruction complete. It saves the instruction's address and the current privilege level, drops the level to zero, and jumps into a shared vector table. The table entry is the event's code placed in PC bits 7:4, with every other bit zero.

The block also owns the small special-register bank: the saved trap PC, the saved fault address, a scratch word, and a view of the privilege fields. It checks that software holds enough privilege to touch this bank. It also performs the return from a handler. A special-register read whose destination is R0 loads the PC from the selected register and restores the privilege level from the saved level, both in one step. Decode, the ALU and memory are outside the block. Decode tells the sequencer whether the instruction is a special-register get or set, which register it names, and whether the destination is R0.

Top module: `trap_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the PC, level, saved level, saved trap PC, saved fault address and scratch register all become zero.
- R2: A retiring instruction (`instr_valid` high) with trap code 0, interrupt code 0, and no special-register return loads the PC from `next_pc`. The level stays unchanged and `commit_en` is high.
- R3: A retiring instruction with a nonzero trap code is aborted (`commit_en` low). The saved trap PC takes the current PC, the saved level takes the level, and the level becomes 0. The PC becomes the code in bits 7:4 with all other bits zero, so code 2 gives 0x20.
- R4: Trap code 1 (bus fault) latches `fault_addr` into the saved fault address. Any other event leaves that register unchanged.
- R5: A nonzero trap code wins over a pending interrupt. In that case `irq_ack` stays low and the vector comes from the trap code.
- R6: With no trap and a nonzero interrupt code, the instruction is aborted and the entry of R3 is made using the interrupt code. `irq_ack` is high in that cycle, so code 0xF gives PC 0xF0.
- R7: A special-register get (`sr_op`=01) or set (`sr_op`=10) attempted while the level is 1111 raises trap code 3, which gives vector 0x30. The access has no effect. A nonzero trap code from the execution unit still takes priority over this.
- R8: A get with `sr_dst_zero` high and no event loads the PC from the selected register and copies the saved level into the level. The saved level is left as it is.
- R9: A set with no event writes `sr_wdata` to the selected register. The register selects are: 0 for the privilege view, 1 for the saved trap PC, 2 for the saved fault address, and 3 for scratch. A set of select 0 loads the level from data bits 31:28 and the saved level from bits 27:24.
- R10: `sr_rdata` always shows the selected register. Select 0 reads as the level in bits 31:28, the saved level in bits 27:24, and zeros below. Selects 4 to 15 read as zero. The scratch register keeps whatever was written to it.
- R11: With `instr_valid` low, no state changes whatever the trap and interrupt codes are, and both `commit_en` and `irq_ack` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| next_pc | input | 32 | PC the instruction would continue to |
| trap_code | input | 4 | Synchronous fault cause, 0 = none |
| fault_addr | input | 32 | Offending memory address for a bus fault |
| irq_code | input | 4 | Pending interrupt vector code, 0 = none |
| sr_op | input | 2 | 00 none, 01 special-register get, 10 set |
| sr_sel | input | 4 | Special-register select |
| sr_dst_zero | input | 1 | Get destination is R0 (return) |
| sr_wdata | input | 32 | Data for a set |
| pc_q | output | 32 | Current program counter |
| level_q | output | 4 | Current privilege level |
| old_level_q | output | 4 | Saved privilege level |
| tpc_q | output | 32 | Saved trap PC |
| tma_q | output | 32 | Saved fault address |
| sr_rdata | output | 32 | Selected special register |
| irq_ack | output | 1 | Interrupt taken, pending vector may clear |
| commit_en | output | 1 | Instruction may write its results |

## Verification
The hardest case to reach is the privilege-violation path. It only arises once software has raised its own level to 1111, and the only way to do that is a set of the privilege view while the level is still permissive. The stimulus therefore first writes 0xF into the level through select 0. It then issues gets and sets that must turn into vector 0x30 without disturbing the scratch word. Between attempts, a return through R0 brings the level back to 1111. A last case combines a privileged access with an execution-unit fault to show which trap wins.

// File: rtl/trap_seq_pkg.sv
// Shared constants and types for the trap sequencer.
// Assumes a 4-bit event code and a 4-bit special-register select.
package trap_seq_pkg;
    localparam int CODE_W = 4;
    localparam int SEL_W  = 4;

    // Fixed cause codes of the shared vector table
    localparam logic [CODE_W-1:0] CODE_NONE   = 4'd0;
    localparam logic [CODE_W-1:0] CODE_BUSERR = 4'd1;
    localparam logic [CODE_W-1:0] CODE_ILLEG  = 4'd2;
    localparam logic [CODE_W-1:0] CODE_PRIV   = 4'd3;

    // Special-register operation encodings
    localparam logic [1:0] SR_NONE = 2'b00;
    localparam logic [1:0] SR_GET  = 2'b01;
    localparam logic [1:0] SR_SET  = 2'b10;

    // Special-register selects
    localparam logic [SEL_W-1:0] SEL_PSW = 4'd0;
    localparam logic [SEL_W-1:0] SEL_TPC = 4'd1;
    localparam logic [SEL_W-1:0] SEL_TMA = 4'd2;
    localparam logic [SEL_W-1:0] SEL_TSV = 4'd3;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_IRQ  = 2'd2
    } event_e;
endpackage

// File: rtl/trap_arbiter.sv
// Picks the event for the retiring instruction: an execution fault first,
// then a privilege fault, then a pending interrupt. Purely combinational.
// Assumes code 0 means "no event" on both request inputs.
module trap_arbiter
    import trap_seq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic              instr_valid,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [1:0]        sr_op,
    input  logic [LVL_W-1:0]  level,
    output event_e            ev,
    output logic [CODE_W-1:0] ev_code
);
    logic              priv_fault;
    logic [CODE_W-1:0] sync_code;

    // Privilege check and synchronous cause selection
    always_comb begin
        priv_fault = (sr_op != SR_NONE) && (level == {LVL_W{1'b1}});
        if (trap_code != CODE_NONE)
            sync_code = trap_code;
        else if (priv_fault)
            sync_code = CODE_PRIV;
        else
            sync_code = CODE_NONE;
    end

    // Event priority: synchronous trap over interrupt
    always_comb begin
        ev      = EV_NONE;
        ev_code = CODE_NONE;
        if (instr_valid) begin
            if (sync_code != CODE_NONE) begin
                ev      = EV_TRAP;
                ev_code = sync_code;
            end else if (irq_code != CODE_NONE) begin
                ev      = EV_IRQ;
                ev_code = irq_code;
            end
        end
    end
endmodule

// File: rtl/trap_sr_bank.sv
// Saved trap PC, saved fault address and scratch word, plus the read mux
// over the whole special-register space. The privilege view is supplied
// by the parent, which also owns its writes.
module trap_sr_bank
    import trap_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic [XLEN-1:0]  enter_pc,
    input  logic             fault_load,
    input  logic [XLEN-1:0]  fault_val,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [XLEN-1:0]  wdata,
    input  logic [XLEN-1:0]  psw_view,
    output logic [XLEN-1:0]  tpc,
    output logic [XLEN-1:0]  tma,
    output logic [XLEN-1:0]  rdata
);
    logic [XLEN-1:0] tsv;

    // Register updates: event entry has priority over software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpc <= '0;
            tma <= '0;
            tsv <= '0;
        end else if (enter) begin
            tpc <= enter_pc;
            if (fault_load)
                tma <= fault_val;
        end else if (wr_en) begin
            case (sel)
                SEL_TPC: tpc <= wdata;
                SEL_TMA: tma <= wdata;
                SEL_TSV: tsv <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux over all selects, unused selects read zero
    always_comb begin
        case (sel)
            SEL_PSW: rdata = psw_view;
            SEL_TPC: rdata = tpc;
            SEL_TMA: rdata = tma;
            SEL_TSV: rdata = tsv;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/trap_seq_ctrl.sv
// Trap entry and return sequencer. Owns the PC and the privilege fields.
// On an event it aborts the instruction, saves PC and level, zeroes the
// level and vectors to code<<VEC_SHIFT. A get into R0 performs the return.
// Assumes one retiring instruction per cycle when instr_valid is high.
module trap_seq_ctrl
    import trap_seq_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int LVL_W     = 4,
    parameter int VEC_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [1:0]        sr_op,
    input  logic [SEL_W-1:0]  sr_sel,
    input  logic              sr_dst_zero,
    input  logic [XLEN-1:0]   sr_wdata,
    output logic [XLEN-1:0]   pc_q,
    output logic [LVL_W-1:0]  level_q,
    output logic [LVL_W-1:0]  old_level_q,
    output logic [XLEN-1:0]   tpc_q,
    output logic [XLEN-1:0]   tma_q,
    output logic [XLEN-1:0]   sr_rdata,
    output logic              irq_ack,
    output logic              commit_en
);
    localparam int PAD_HI = XLEN - CODE_W - VEC_SHIFT;
    localparam int PAD_LO = XLEN - 2 * LVL_W;

    event_e            ev;
    logic [CODE_W-1:0] ev_code;
    logic [XLEN-1:0]   vec_pc;
    logic [XLEN-1:0]   psw_view;
    logic              quiet;
    logic              do_ret;
    logic              do_set;
    logic              set_psw;

    trap_arbiter #(.LVL_W(LVL_W)) u_arb (
        .instr_valid (instr_valid),
        .trap_code   (trap_code),
        .irq_code    (irq_code),
        .sr_op       (sr_op),
        .level       (level_q),
        .ev          (ev),
        .ev_code     (ev_code)
    );

    // Decode of the retiring instruction when no event is taken
    always_comb begin
        quiet     = instr_valid && (ev == EV_NONE);
        do_ret    = quiet && (sr_op == SR_GET) && sr_dst_zero;
        do_set    = quiet && (sr_op == SR_SET);
        set_psw   = do_set && (sr_sel == SEL_PSW);
        vec_pc    = {{PAD_HI{1'b0}}, ev_code, {VEC_SHIFT{1'b0}}};
        psw_view  = {level_q, old_level_q, {PAD_LO{1'b0}}};
        commit_en = quiet;
        irq_ack   = (ev == EV_IRQ);
    end

    trap_sr_bank #(.XLEN(XLEN)) u_srb (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (ev != EV_NONE),
        .enter_pc   (pc_q),
        .fault_load ((ev == EV_TRAP) && (ev_code == CODE_BUSERR)),
        .fault_val  (fault_addr),
        .wr_en      (do_set),
        .sel        (sr_sel),
        .wdata      (sr_wdata),
        .psw_view   (psw_view),
        .tpc        (tpc_q),
        .tma        (tma_q),
        .rdata      (sr_rdata)
    );

    // PC and privilege fields: reset, event entry, return, software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= '0;
            level_q     <= '0;
            old_level_q <= '0;
        end else if (instr_valid) begin
            if (ev != EV_NONE) begin
                pc_q        <= vec_pc;
                old_level_q <= level_q;
                level_q     <= '0;
            end else if (do_ret) begin
                pc_q    <= sr_rdata;
                level_q <= old_level_q;
            end else begin
                pc_q <= next_pc;
                if (set_psw) begin
                    level_q     <= sr_wdata[XLEN-1 -: LVL_W];
                    old_level_q <= sr_wdata[XLEN-1-LVL_W -: LVL_W];
                end
            end
        end
    end
endmodule

// File: rtl/trap_seq_chk.sv
// Temporal checks on the sequencer's ports, bound into every instance.
module trap_seq_chk #(
    parameter int XLEN      = 32,
    parameter int LVL_W     = 4,
    parameter int VEC_SHIFT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [3:0]      trap_code,
    input logic [3:0]      irq_code,
    input logic [XLEN-1:0] fault_addr,
    input logic [XLEN-1:0] pc_q,
    input logic [LVL_W-1:0] level_q,
    input logic [LVL_W-1:0] old_level_q,
    input logic [XLEN-1:0] tpc_q,
    input logic [XLEN-1:0] tma_q,
    input logic            irq_ack,
    input logic            commit_en
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && level_q == '0 && tpc_q == '0 && tma_q == '0));

    assert_trap_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && trap_code != 4'd0) |=>
        (level_q == '0 && old_level_q == $past(level_q) && tpc_q == $past(pc_q)
         && pc_q == (XLEN'($past(trap_code)) << VEC_SHIFT)));

    assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && trap_code == 4'd1) |=> (tma_q == $past(fault_addr)));

    assert_trap_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && trap_code != 4'd0) |-> (!irq_ack && !commit_en));

    assert_irq_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (level_q == '0 && pc_q == (XLEN'($past(irq_code)) << VEC_SHIFT)));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (instr_valid && irq_code != 4'd0 && !commit_en));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(pc_q) && $stable(level_q) && $stable(old_level_q)
                          && $stable(tpc_q) && $stable(tma_q)));
endmodule

bind trap_seq_ctrl trap_seq_chk #(
    .XLEN(XLEN), .LVL_W(LVL_W), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .trap_code   (trap_code),
    .irq_code    (irq_code),
    .fault_addr  (fault_addr),
    .pc_q        (pc_q),
    .level_q     (level_q),
    .old_level_q (old_level_q),
    .tpc_q       (tpc_q),
    .tma_q       (tma_q),
    .irq_ack     (irq_ack),
    .commit_en   (commit_en)
);

// File: tb/tb_trap_seq_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected state from the
// requirements and queues it; the monitor pops and compares after each edge.
module tb_trap_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] next_pc = '0;
    logic [3:0]  trap_code = '0;
    logic [31:0] fault_addr = '0;
    logic [3:0]  irq_code = '0;
    logic [1:0]  sr_op = '0;
    logic [3:0]  sr_sel = '0;
    logic        sr_dst_zero = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] pc_q, tpc_q, tma_q, sr_rdata;
    logic [3:0]  level_q, old_level_q;
    logic        irq_ack, commit_en;

    always #2 clk = ~clk;

    trap_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .next_pc(next_pc),
        .trap_code(trap_code), .fault_addr(fault_addr), .irq_code(irq_code),
        .sr_op(sr_op), .sr_sel(sr_sel), .sr_dst_zero(sr_dst_zero),
        .sr_wdata(sr_wdata), .pc_q(pc_q), .level_q(level_q),
        .old_level_q(old_level_q), .tpc_q(tpc_q), .tma_q(tma_q),
        .sr_rdata(sr_rdata), .irq_ack(irq_ack), .commit_en(commit_en)
    );

    typedef struct {
        logic [31:0] pc;
        logic [3:0]  lvl;
        logic [3:0]  old;
        logic [31:0] tpc;
        logic [31:0] tma;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;

    // Reference state kept from the requirements
    logic [31:0] m_pc = '0, m_tpc = '0, m_tma = '0, m_tsv = '0;
    logic [3:0]  m_lvl = '0, m_old = '0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [3:0] sel);
        case (sel)
            4'd0:    return {m_lvl, m_old, 24'h0};
            4'd1:    return m_tpc;
            4'd2:    return m_tma;
            4'd3:    return m_tsv;
            default: return 32'h0;
        endcase
    endfunction

    // Monitor: compare registered state one step after each queued edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "pc", pc_q, e.pc);
            chk(e.tag, "level", {28'h0, level_q}, {28'h0, e.lvl});
            chk(e.tag, "old_level", {28'h0, old_level_q}, {28'h0, e.old});
            chk(e.tag, "tpc", tpc_q, e.tpc);
            chk(e.tag, "tma", tma_q, e.tma);
        end
    end

    task automatic do_reset(input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        m_pc = '0; m_tpc = '0; m_tma = '0; m_tsv = '0; m_lvl = '0; m_old = '0;
        e = '{pc: '0, lvl: '0, old: '0, tpc: '0, tma: '0, tag: tag};
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: apply one instruction, check combinational outputs, queue state
    task automatic step(input logic v, input logic [3:0] tc, input logic [31:0] fa,
                        input logic [3:0] ic, input logic [1:0] op,
                        input logic [3:0] sel, input logic dz,
                        input logic [31:0] wd, input string tag);
        logic       priv;
        logic [3:0] sc;
        logic [3:0] code;
        int         ev;
        exp_t       e;
        @(negedge clk);
        instr_valid = v; trap_code = tc; fault_addr = fa; irq_code = ic;
        sr_op = op; sr_sel = sel; sr_dst_zero = dz; sr_wdata = wd;
        next_pc = m_pc + 32'd4;
        priv = (op != 2'b00) && (m_lvl == 4'hF);
        sc = (tc != 0) ? tc : (priv ? 4'd3 : 4'd0);
        ev = 0; code = 0;
        if (v && sc != 0) begin ev = 1; code = sc; end
        else if (v && ic != 0) begin ev = 2; code = ic; end
        #0.5;
        chk(tag, "commit_en", {31'h0, commit_en}, {31'h0, (v && ev == 0)});
        chk(tag, "irq_ack", {31'h0, irq_ack}, {31'h0, (ev == 2)});
        chk(tag, "sr_rdata", sr_rdata, m_read(sel));
        if (v) begin
            if (ev != 0) begin
                m_tpc = m_pc;
                if (ev == 1 && code == 4'd1) m_tma = fa;
                m_old = m_lvl;
                m_lvl = 4'h0;
                m_pc = {24'h0, code, 4'h0};
            end else if (op == 2'b01 && dz) begin
                m_pc = m_read(sel);
                m_lvl = m_old;
            end else begin
                m_pc = m_pc + 32'd4;
                if (op == 2'b10) begin
                    case (sel)
                        4'd0: begin m_lvl = wd[31:28]; m_old = wd[27:24]; end
                        4'd1: m_tpc = wd;
                        4'd2: m_tma = wd;
                        4'd3: m_tsv = wd;
                        default: ;
                    endcase
                end
            end
        end
        e = '{pc: m_pc, lvl: m_lvl, old: m_old, tpc: m_tpc, tma: m_tma, tag: tag};
        q.push_back(e);
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset("R1");
        step(1, 0, 0, 0, 2'b01, 4'd3, 0, 0, "R1");                   // scratch reads zero after reset
        step(1, 0, 0, 0, 2'b00, 4'd0, 0, 0, "R2");
        step(1, 0, 0, 0, 2'b00, 4'd9, 0, 0, "R2");
        step(1, 0, 0, 0, 2'b10, 4'd3, 0, 32'hDEADBEEF, "R9");        // scratch write
        step(1, 0, 0, 0, 2'b01, 4'd3, 0, 0, "R10");                  // scratch read back
        step(1, 0, 0, 0, 2'b10, 4'd0, 0, 32'h52000000, "R9");        // level 5, saved 2
        step(1, 0, 0, 0, 2'b01, 4'd0, 0, 0, "R10");                  // privilege view
        step(1, 4'd2, 32'h55, 4'd7, 2'b00, 4'd0, 0, 0, "R5");        // trap beats irq
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");                   // return
        step(1, 4'd1, 32'h12345678, 0, 2'b00, 4'd2, 0, 0, "R4");     // bus fault
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");
        step(1, 4'd2, 32'hFFFF0000, 0, 2'b00, 4'd2, 0, 0, "R4");     // tma kept
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");
        step(1, 0, 0, 4'd9, 2'b10, 4'd3, 0, 32'h1, "R6");            // irq, set discarded
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");
        step(1, 0, 0, 4'hF, 2'b00, 4'd0, 0, 0, "R6");                // top vector 0xF0
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");
        step(1, 0, 0, 0, 2'b10, 4'd0, 0, 32'hF0000000, "R9");        // level 1111
        step(1, 0, 0, 0, 2'b01, 4'd3, 0, 0, "R7");                   // get faults
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");                   // back to 1111
        step(1, 0, 0, 0, 2'b10, 4'd3, 0, 32'h11, "R7");              // set faults
        step(1, 0, 0, 0, 2'b01, 4'd1, 1, 0, "R8");
        step(1, 4'd2, 0, 0, 2'b10, 4'd3, 0, 32'h22, "R7");           // unit fault wins
        step(1, 0, 0, 0, 2'b01, 4'd3, 0, 0, "R7");                   // scratch untouched
        step(0, 4'd2, 32'h99, 4'd3, 2'b10, 4'd3, 0, 32'h33, "R11");
        step(0, 4'd1, 32'h77, 4'd0, 2'b01, 4'd1, 1, 0, "R11");
        step(1, 0, 0, 0, 2'b01, 4'd12, 0, 0, "R10");                 // unused select
        step(1, 0, 0, 0, 2'b10, 4'd2, 0, 32'hCAFE0000, "R9");        // tma write
        do_reset("R1");
        step(1, 0, 0, 0, 2'b01, 4'd3, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule